// File: doc/BRIEF.md
# Registered-IO Synchronous Word Memory

This block is a single-clock static memory of 9-bit words with a separate input data bus and output data bus. Every input it receives (address, write data and the three active-low controls) is captured in a register on the rising clock edge, and the output word leaves through a second register. The result appears on the output one clock edge after the edge that sampled the request. The depth is a parameter, small enough to map onto on-chip RAM, and the address width is derived from it.

The chip enable never deselects the memory. It only decides whether a sampled write reaches the array. When a write is sampled with the enable high, the input word still travels to the output as a pass-through, but nothing is stored. When a write is sampled with the enable low, the word is stored and is also shown on the output (a transparent write). The output enable is the only control that takes the output off the bus. The block drives a separate drive-enable pin for an external three-state pad.

Top module: `regio_sram`

## Requirements
- R1: Inputs are sampled on the rising edge of `clk`. The result of a request sampled at edge N is on `q_o`/`q_oe_o` after edge N+1 and stays there until edge N+2.
- R2: While `rst_n` is low, the sampled controls are forced to their inactive state. After the first edge in reset, `q_oe_o` is 0 and `q_o` is 0, and no write reaches the array.
- R3: A request sampled with `wr_n_i` high returns the stored word at the sampled address on `q_o`.
- R4: A request sampled with `wr_n_i` low and `ce_n_i` low stores `din_i` at the sampled address and presents the same word on `q_o` (transparent write).
- R5: A request sampled with `wr_n_i` low and `ce_n_i` high presents `din_i` on `q_o` and leaves the array unchanged (pass-through).
- R6: `ce_n_i` high does not stop reads. A read sampled with `ce_n_i` high returns the stored word, and `q_oe_o` is still 1 when `oe_n_i` was sampled low.
- R7: `q_oe_o` is 1 exactly when `oe_n_i` was sampled low. It follows the same latency as the data (R1).
- R8: A read on the cycle right after a write to the same address returns the newly written word.
- R9: `oe_n_i` high does not block storage. A write sampled with `oe_n_i` high is later read back intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Word address (ADDR_W = clog2(DEPTH)) |
| din_i | input | WORD_W | Write / pass-through data |
| wr_n_i | input | 1 | Write request, active low |
| ce_n_i | input | 1 | Array write gate, active low |
| oe_n_i | input | 1 | Output drive request, active low |
| q_o | output | WORD_W | Registered output word |
| q_oe_o | output | 1 | Drive enable for the external three-state pad, active high |

## Verification
Two functions can fall in the same cycle. A read may sit at the array on the very edge that completes a write to the same address, and a pass-through may hit an address whose stored contents the bench then reads back. The bench provokes the first with back-to-back write-then-read pairs and judges it by the new word appearing. It provokes the second with pass-through followed by a read of the same location and judges it by the old word surviving. A long mixed stream of random addresses and controls over a small address window then makes these collisions frequent. A behavioural model compares both outputs on every clock.

// File: rtl/regio_pkg.sv
// Package: shared types for the registered-IO memory.
// Assumes: controls are carried internally as active-high bits.
package regio_pkg;
    typedef struct packed {
        logic wr;   // write requested
        logic ce;   // array write permitted
        logic oe;   // output drive requested
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{wr: 1'b0, ce: 1'b0, oe: 1'b0};
endpackage

// File: rtl/regio_in_stage.sv
// Module: input capture registers.
// Samples the address, data and the active-low controls on every rising edge.
// Assumes a synchronous active-low reset; controls are inverted to active high.
module regio_in_stage
    import regio_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              wr_n_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    output logic [ADDR_W-1:0] addr_r,
    output logic [WORD_W-1:0] din_r,
    output ctl_t              ctl_r
);
    // Capture all request fields; reset leaves every control inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_r <= '0;
            din_r  <= '0;
            ctl_r  <= CTL_IDLE;
        end else begin
            addr_r   <= addr_i;
            din_r    <= din_i;
            ctl_r.wr <= ~wr_n_i;
            ctl_r.ce <= ~ce_n_i;
            ctl_r.oe <= ~oe_n_i;
        end
    end
endmodule

// File: rtl/regio_array.sv
// Module: word storage with one write port and one combinational read port.
// Contents are not initialised. The read returns the word held before
// the current edge's write.
module regio_array #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 9,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    // Store the word when the write strobe is set.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Present the word at the registered address.
    always_comb begin
        rdata = cells[addr];
    end
endmodule

// File: rtl/regio_out_stage.sv
// Module: output register and drive-enable register.
// A sampled write loads the input word, otherwise the array word is loaded.
// Assumes controls arrive already registered.
module regio_out_stage
    import regio_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_r,
    input  logic [WORD_W-1:0] din_r,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] q_o,
    output logic              q_oe_o
);
    logic [WORD_W-1:0] next_q;

    // Choose between the forwarded input word and the stored word.
    always_comb begin
        next_q = ctl_r.wr ? din_r : rdata;
    end

    // Load the output word and its drive enable together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o    <= '0;
            q_oe_o <= 1'b0;
        end else begin
            q_o    <= next_q;
            q_oe_o <= ctl_r.oe;
        end
    end
endmodule

// File: rtl/regio_sram.sv
// Module: top of the registered-IO memory.
// Chains the input registers, the array and the output register.
// The chip enable gates only the array write; it never deselects.
module regio_sram
    import regio_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 9,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              wr_n_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    output logic [WORD_W-1:0] q_o,
    output logic              q_oe_o
);
    logic [ADDR_W-1:0] addr_r;
    logic [WORD_W-1:0] din_r;
    logic [WORD_W-1:0] rdata;
    ctl_t              ctl_r;
    logic              arr_we;

    regio_in_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) in_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .wr_n_i(wr_n_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .addr_r(addr_r), .din_r(din_r), .ctl_r(ctl_r)
    );

    // Write into the array only when both write and enable were sampled.
    always_comb begin
        arr_we = ctl_r.wr & ctl_r.ce;
    end

    regio_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) arr_i (
        .clk(clk), .we(arr_we), .addr(addr_r), .wdata(din_r), .rdata(rdata)
    );

    regio_out_stage #(.WORD_W(WORD_W)) out_i (
        .clk(clk), .rst_n(rst_n), .ctl_r(ctl_r), .din_r(din_r),
        .rdata(rdata), .q_o(q_o), .q_oe_o(q_oe_o)
    );
endmodule

// File: rtl/regio_sram_chk.sv
// Module: assertion checker bound to regio_sram.
// Relates the ports across the two-register latency and the write strobe.
module regio_sram_chk #(
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n_i,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic [WORD_W-1:0] din_i,
    input logic [WORD_W-1:0] q_o,
    input logic              q_oe_o,
    input logic              arr_we
);
    logic [1:0] live;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= 2'd0;
        else if (live != 2'd2) live <= live + 2'd1;
    end

    a_r2_reset_outputs_off: assert property (@(posedge clk)
        !rst_n |=> (!q_oe_o && q_o == '0));

    a_r7_drive_follows_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd2) |-> (q_oe_o == !$past(oe_n_i, 2)));

    a_r5_write_data_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd2 && !$past(wr_n_i, 2)) |-> (q_o == $past(din_i, 2)));

    a_r4_store_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (live != 2'd0) |-> (arr_we == $past(!wr_n_i && !ce_n_i)));

    a_r6_ce_keeps_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd2 && $past(ce_n_i, 2) && !$past(oe_n_i, 2)) |-> q_oe_o);
endmodule

bind regio_sram regio_sram_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n_i), .ce_n_i(ce_n_i),
    .oe_n_i(oe_n_i), .din_i(din_i), .q_o(q_o), .q_oe_o(q_oe_o),
    .arr_we(arr_we)
);

// File: tb/regio_sram_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module regio_sram_tb_top;
    localparam int DEPTH  = 1024;
    localparam int WORD_W = 9;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [WORD_W-1:0] din_i = '0;
    logic              wr_n_i = 1'b1, ce_n_i = 1'b1, oe_n_i = 1'b1;
    logic [WORD_W-1:0] q_o;
    logic              q_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [WORD_W-1:0] mem_m [DEPTH];
    bit                known [DEPTH];
    bit                p_valid = 0;
    int                p_addr = 0;
    logic [WORD_W-1:0] p_din = '0;
    bit                p_wr = 0, p_ce = 0, p_oe = 0;
    bit                prev_stored = 0;
    int                prev_addr = -1;

    always #2.5 clk = ~clk;

    regio_sram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .wr_n_i(wr_n_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .q_o(q_o), .q_oe_o(q_oe_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One request: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input int a, input int d, input bit wr, input bit ce, input bit oe);
        logic [WORD_W-1:0] eq;
        bit                ek, eoe, stored_now;
        string             tag;
        addr_i = a[ADDR_W-1:0];
        din_i  = d[WORD_W-1:0];
        wr_n_i = !wr; ce_n_i = !ce; oe_n_i = !oe;
        @(posedge clk);
        ek = 0; eq = '0; eoe = 0; stored_now = 0; tag = "";
        if (p_valid) begin
            eoe = p_oe;
            if (p_wr) begin
                eq = p_din; ek = 1;
                tag = p_ce ? "R1 R4 transparent" : "R1 R5 pass-through";
            end else begin
                eq = mem_m[p_addr]; ek = known[p_addr];
                if (!p_ce)                                  tag = "R1 R6 read-ce-high";
                else if (prev_stored && prev_addr == p_addr) tag = "R1 R8 read-after-write";
                else                                         tag = "R1 R3 read";
            end
            if (p_wr && p_ce) begin
                mem_m[p_addr] = p_din; known[p_addr] = 1; stored_now = 1;
            end
        end
        prev_stored = stored_now;
        prev_addr   = p_addr;
        p_valid = 1; p_addr = a; p_din = d[WORD_W-1:0];
        p_wr = wr; p_ce = ce; p_oe = oe;
        @(negedge clk);
        if (p_valid && tag != "") begin
            check(q_oe_o == eoe, "R7 drive enable", int'(q_oe_o), int'(eoe));
            if (ek) check(q_o == eq, tag, int'(q_o), int'(eq));
        end
    endtask

    initial begin
        logic [WORD_W-1:0] keep5;
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        repeat (3) @(negedge clk);
        check(q_oe_o == 1'b0, "R2 reset drive", int'(q_oe_o), 0);
        check(q_o == '0, "R2 reset data", int'(q_o), 0);
        rst_n = 1'b1;
        // model: registers hold the idle request from reset
        p_valid = 1; p_addr = 0; p_wr = 0; p_ce = 0; p_oe = 0; p_din = '0;
        // prefill with transparent writes
        for (int i = 0; i < DEPTH; i++) step(i, (i * 37 + 11) % 512, 1, 1, 1);
        // pass-through must not store (R5)
        keep5 = mem_m[5];
        step(5, 9'h1AA, 1, 0, 1);
        step(5, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        check(q_o == keep5, "R5 array untouched", int'(q_o), int'(keep5));
        // read with ce high (R6)
        step(6, 0, 0, 0, 1);
        step(6, 0, 0, 0, 0);
        // read right after write (R8)
        step(7, 9'h0F3, 1, 1, 1);
        step(7, 0, 0, 1, 1);
        step(7, 9'h10C, 1, 1, 0);
        step(7, 0, 0, 1, 1);
        // write with output disabled, later read (R9)
        step(9, 9'h155, 1, 1, 0);
        step(0, 0, 0, 1, 0);
        step(9, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        check(q_o == 9'h155, "R9 stored with oe off", int'(q_o), 'h155);
        // mixed stream over a small window to force collisions
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 15), $urandom_range(0, 511),
                 $urandom_range(0, 1), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 3) != 0);
        end
        // reset again mid-run (R2)
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(q_oe_o == 1'b0, "R2 reset drive", int'(q_oe_o), 0);
        check(q_o == '0, "R2 reset data", int'(q_o), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule